// File: doc/BRIEF.md
# Indexed host configuration port

This block is the host-facing configuration window of a chip that carries several logical devices. The host reaches it through two byte-wide I/O addresses. The index port selects a configuration register. The data port reads or writes the register that is selected. A single global register picks which logical device the banked registers refer to. Each device has its own activate bit, a 16-bit base address and a configuration-select byte. Read-only identity bytes describe the chip.

The port is closed after reset. A key byte written to the index port opens it, and a second key byte closes it again. While the port is closed, the block ignores data writes and answers every read with all ones. The per-device registers drive flat output vectors that the logical devices downstream use as their settings. The host bus is a synchronous interface with one-cycle read and write strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `hcfg_port`

## Requirements
- R1: After reset the port is closed (`cfg_mode` = 0), `io_rdata` is 0x00, and every activate bit, base address and configuration-select byte is zero.
- R2: While closed, data-port writes change nothing, and index-port writes of any value other than 0x55 leave the port closed with the index unchanged. Reads of either port return 0xFF.
- R3: Writing 0x55 to the index port while closed opens the port from the next cycle. Writing 0xAA to the index port while open closes it.
- R4: While open, an index-port write of any value other than 0xAA loads that value as the current index. An index-port read returns the current index.
- R5: Index 0x07 holds the 8-bit logical device number. It is global, readable and writable, and is not banked.
- R6: Index 0x30 is the activate register of the selected device. Only bit 0 is stored, it reads back as {7'b0, bit}, and it drives `dev_active[n]` for device n.
- R7: Index 0x34 is the low byte and index 0x35 the high byte of the selected device's 16-bit base address, which drives `dev_base[16*n +: 16]`.
- R8: Index 0xF0 is the selected device's 8-bit configuration-select byte, which drives `dev_cfgsel[8*n +: 8]`.
- R9: When the device number is NUM_DEV or higher, the banked indices read 0x00 and writes to them have no effect.
- R10: The identity bytes are read-only. Index 0x20 returns the device ID high byte, 0x21 the device ID low byte, 0x22 the sub-ID, 0x23 the revision and 0x24 the fixed legacy byte 0xFE. Writes to these indices have no effect.
- R11: An index with no register behind it reads 0x00, and writes to it have no effect.
- R12: Read data appears on `io_rdata` in the cycle after the read strobe and holds until the next read of either port.
- R13: Banked registers are independent. A write to one device leaves every other device unchanged, and a device keeps its values while other devices are selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data byte |
| cfg_mode | output | 1 | High while the port is open |
| dev_active | output | NUM_DEV | Activate bit per logical device |
| dev_base | output | NUM_DEV*16 | Base address per device, device n at bits 16n+15:16n |
| dev_cfgsel | output | NUM_DEV*8 | Configuration-select byte per device, device n at bits 8n+7:8n |

## Verification
The bench builds the block with NUM_DEV = 4 and non-default identity values (device ID 0xA5C3, sub-ID 0x41, revision 0x03). With only four devices, a device number of 5 is out of range, so the bench can check that banked reads return zero and banked writes are dropped. The identity values are distinct from zero and from each other, so a swapped byte, a wrong byte position or a writable identity register shows up in the read data. The bench leaves the two port addresses at their defaults.

// File: rtl/hcfg_pkg.sv
`timescale 1ns/1ps
package hcfg_pkg;

    // Key bytes recognised on the index port
    localparam logic [7:0] KEY_OPEN   = 8'h55;
    localparam logic [7:0] KEY_CLOSE  = 8'hAA;

    // Register indices
    localparam logic [7:0] IX_LDN     = 8'h07;
    localparam logic [7:0] IX_ID_HI   = 8'h20;
    localparam logic [7:0] IX_ID_LO   = 8'h21;
    localparam logic [7:0] IX_SUBID   = 8'h22;
    localparam logic [7:0] IX_REV     = 8'h23;
    localparam logic [7:0] IX_LEGACY  = 8'h24;
    localparam logic [7:0] IX_ACT     = 8'h30;
    localparam logic [7:0] IX_BASE_LO = 8'h34;
    localparam logic [7:0] IX_BASE_HI = 8'h35;
    localparam logic [7:0] IX_CFGSEL  = 8'hF0;

    localparam logic [7:0] LEGACY_VAL = 8'hFE;
    localparam logic [7:0] CLOSED_RD  = 8'hFF;

    typedef struct packed {
        logic       open;
        logic [7:0] index;
        logic [7:0] ldn;
    } key_state_t;

    typedef struct packed {
        logic        active;
        logic [15:0] base;
        logic [7:0]  cfgsel;
    } dev_regs_t;

    typedef struct packed {
        logic [7:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/hcfg_key_ctrl.sv
`timescale 1ns/1ps
module hcfg_key_ctrl
    import hcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic       open,
    output logic [7:0] index,
    output logic [7:0] ldn
);

    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            if (!st_q.open) begin
                if (wdata == KEY_OPEN) begin
                    st_d.open = 1'b1;
                end
            end else if (wdata == KEY_CLOSE) begin
                st_d.open = 1'b0;
            end else begin
                st_d.index = wdata;
            end
        end
        if (dat_wr && st_q.open && (st_q.index == IX_LDN)) begin
            st_d.ldn = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open  = st_q.open;
    assign index = st_q.index;
    assign ldn   = st_q.ldn;

endmodule

// File: rtl/hcfg_dev_bank.sv
`timescale 1ns/1ps
module hcfg_dev_bank
    import hcfg_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                index,
    input  logic [7:0]                ldn,
    input  logic [7:0]                wdata,
    output logic [NUM_DEV-1:0]        active,
    output logic [NUM_DEV-1:0][15:0]  base,
    output logic [NUM_DEV-1:0][7:0]   cfgsel
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        dev_regs_t r_d, r_q;
        logic      hit;

        assign hit = wr_en && (ldn == 8'(g));

        always_comb begin
            r_d = r_q;
            if (hit) begin
                case (index)
                    IX_ACT:     r_d.active     = wdata[0];
                    IX_BASE_LO: r_d.base[7:0]  = wdata;
                    IX_BASE_HI: r_d.base[15:8] = wdata;
                    IX_CFGSEL:  r_d.cfgsel     = wdata;
                    default:    r_d            = r_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign active[g] = r_q.active;
        assign base[g]   = r_q.base;
        assign cfgsel[g] = r_q.cfgsel;
    end

endmodule

// File: rtl/hcfg_read_mux.sv
`timescale 1ns/1ps
module hcfg_read_mux
    import hcfg_pkg::*;
#(
    parameter int          NUM_DEV = 8,
    parameter logic [15:0] DEV_ID  = 16'h0040,
    parameter logic [7:0]  SUB_ID  = 8'h12,
    parameter logic [7:0]  REV_ID  = 8'h01
) (
    input  logic [7:0]               index,
    input  logic [7:0]               ldn,
    input  logic [NUM_DEV-1:0]       active,
    input  logic [NUM_DEV-1:0][15:0] base,
    input  logic [NUM_DEV-1:0][7:0]  cfgsel,
    output logic [7:0]               rd_byte
);

    localparam int         SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam logic [8:0] NDEV_U  = 9'(NUM_DEV);

    logic             in_range;
    logic [SEL_W-1:0] sel;

    assign in_range = ({1'b0, ldn} < NDEV_U);
    assign sel      = ldn[SEL_W-1:0];

    always_comb begin
        rd_byte = '0;
        case (index)
            IX_LDN:     rd_byte = ldn;
            IX_ID_HI:   rd_byte = DEV_ID[15:8];
            IX_ID_LO:   rd_byte = DEV_ID[7:0];
            IX_SUBID:   rd_byte = SUB_ID;
            IX_REV:     rd_byte = REV_ID;
            IX_LEGACY:  rd_byte = LEGACY_VAL;
            IX_ACT:     if (in_range) rd_byte = {7'b0, active[sel]};
            IX_BASE_LO: if (in_range) rd_byte = base[sel][7:0];
            IX_BASE_HI: if (in_range) rd_byte = base[sel][15:8];
            IX_CFGSEL:  if (in_range) rd_byte = cfgsel[sel];
            default:    rd_byte = '0;
        endcase
    end

endmodule

// File: rtl/hcfg_port.sv
`timescale 1ns/1ps
module hcfg_port
    import hcfg_pkg::*;
#(
    parameter int          NUM_DEV    = 8,
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] DATA_ADDR  = 16'h002F,
    parameter logic [15:0] DEV_ID     = 16'h0040,
    parameter logic [7:0]  SUB_ID     = 8'h12,
    parameter logic [7:0]  REV_ID     = 8'h01
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [7:0]              io_wdata,
    output logic [7:0]              io_rdata,
    output logic                    cfg_mode,
    output logic [NUM_DEV-1:0]      dev_active,
    output logic [NUM_DEV*16-1:0]   dev_base,
    output logic [NUM_DEV*8-1:0]    dev_cfgsel
);

    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(INDEX_ADDR);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_ADDR);

    logic                     idx_hit, dat_hit;
    logic                     open;
    logic [7:0]               index, ldn, mux_byte;
    logic [NUM_DEV-1:0]       act_w;
    logic [NUM_DEV-1:0][15:0] base_w;
    logic [NUM_DEV-1:0][7:0]  csel_w;
    rd_state_t                rd_d, rd_q;

    assign idx_hit = (io_addr == IDX_A);
    assign dat_hit = (io_addr == DAT_A);

    hcfg_key_ctrl u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (io_wr && idx_hit),
        .dat_wr (io_wr && dat_hit),
        .wdata  (io_wdata),
        .open   (open),
        .index  (index),
        .ldn    (ldn)
    );

    hcfg_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (io_wr && dat_hit && open),
        .index  (index),
        .ldn    (ldn),
        .wdata  (io_wdata),
        .active (act_w),
        .base   (base_w),
        .cfgsel (csel_w)
    );

    hcfg_read_mux #(
        .NUM_DEV (NUM_DEV),
        .DEV_ID  (DEV_ID),
        .SUB_ID  (SUB_ID),
        .REV_ID  (REV_ID)
    ) u_mux (
        .index   (index),
        .ldn     (ldn),
        .active  (act_w),
        .base    (base_w),
        .cfgsel  (csel_w),
        .rd_byte (mux_byte)
    );

    always_comb begin
        rd_d = rd_q;
        if (io_rd && idx_hit) begin
            rd_d.rdata = open ? index : CLOSED_RD;
        end else if (io_rd && dat_hit) begin
            rd_d.rdata = open ? mux_byte : CLOSED_RD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign io_rdata   = rd_q.rdata;
    assign cfg_mode   = open;
    assign dev_active = act_w;
    assign dev_base   = base_w;
    assign dev_cfgsel = csel_w;

endmodule

// File: rtl/hcfg_port_chk.sv
`timescale 1ns/1ps
module hcfg_port_chk #(
    parameter int          NUM_DEV    = 8,
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] DATA_ADDR  = 16'h002F
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     io_addr,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [7:0]            io_wdata,
    input logic [7:0]            io_rdata,
    input logic                  cfg_mode,
    input logic [NUM_DEV-1:0]    dev_active,
    input logic [NUM_DEV*16-1:0] dev_base,
    input logic [NUM_DEV*8-1:0]  dev_cfgsel
);

    logic at_idx, at_dat;
    assign at_idx = (io_addr == ADDR_W'(INDEX_ADDR));
    assign at_dat = (io_addr == ADDR_W'(DATA_ADDR));

    // R2
    closed_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_wr && at_dat) |=>
            ($stable(dev_active) && $stable(dev_base) && $stable(dev_cfgsel)));

    // R2
    closed_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_rd && (at_idx || at_dat)) |=> (io_rdata == 8'hFF));

    // R2
    closed_stays_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && !(io_wr && at_idx && io_wdata == 8'h55)) |=> !cfg_mode);

    // R3
    open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_wr && at_idx && io_wdata == 8'h55) |=> cfg_mode);

    // R3
    close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_wr && at_idx && io_wdata == 8'hAA) |=> !cfg_mode);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && (at_idx || at_dat)) |=> $stable(io_rdata));

    // R13
    bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && at_dat) |=>
            ($stable(dev_active) && $stable(dev_base) && $stable(dev_cfgsel)));

endmodule

bind hcfg_port hcfg_port_chk #(
    .NUM_DEV    (NUM_DEV),
    .ADDR_W     (ADDR_W),
    .INDEX_ADDR (INDEX_ADDR),
    .DATA_ADDR  (DATA_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .cfg_mode   (cfg_mode),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .dev_cfgsel (dev_cfgsel)
);

// File: tb/hcfg_port_bench.sv
`timescale 1ns/1ps
module hcfg_port_bench;

    localparam int          NDEV  = 4;
    localparam logic [15:0] IDX_P = 16'h002E;
    localparam logic [15:0] DAT_P = 16'h002F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       io_addr = '0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic              cfg_mode;
    logic [NDEV-1:0]   dev_active;
    logic [NDEV*16-1:0] dev_base;
    logic [NDEV*8-1:0]  dev_cfgsel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hcfg_port #(
        .NUM_DEV (NDEV),
        .DEV_ID  (16'hA5C3),
        .SUB_ID  (8'h41),
        .REV_ID  (8'h03)
    ) u_hcfg_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .cfg_mode   (cfg_mode),
        .dev_active (dev_active),
        .dev_base   (dev_base),
        .dev_cfgsel (dev_cfgsel)
    );

    typedef enum logic [1:0] { K_WR = 2'd0, K_CMP = 2'd1 } kind_t;
    typedef struct packed {
        kind_t      kind;
        logic [7:0] idx;
        logic [7:0] val;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{K_WR,  8'h07, 8'h02, 4'd5},   // R5 select device 2
        '{K_CMP, 8'h07, 8'h02, 4'd5},
        '{K_WR,  8'h30, 8'h01, 4'd6},   // R6
        '{K_CMP, 8'h30, 8'h01, 4'd6},
        '{K_WR,  8'h34, 8'h78, 4'd7},   // R7
        '{K_WR,  8'h35, 8'h56, 4'd7},
        '{K_CMP, 8'h34, 8'h78, 4'd7},
        '{K_CMP, 8'h35, 8'h56, 4'd7},
        '{K_WR,  8'hF0, 8'h9C, 4'd8},   // R8
        '{K_CMP, 8'hF0, 8'h9C, 4'd8},
        '{K_WR,  8'h07, 8'h01, 4'd13},  // R13 device 1 untouched
        '{K_CMP, 8'h30, 8'h00, 4'd13},
        '{K_CMP, 8'h34, 8'h00, 4'd13},
        '{K_CMP, 8'hF0, 8'h00, 4'd13},
        '{K_WR,  8'h30, 8'hFE, 4'd6},   // R6 bit 0 only
        '{K_CMP, 8'h30, 8'h00, 4'd6},
        '{K_WR,  8'h30, 8'hFF, 4'd6},
        '{K_CMP, 8'h30, 8'h01, 4'd6},
        '{K_CMP, 8'h20, 8'hA5, 4'd10},  // R10 identity bytes
        '{K_CMP, 8'h21, 8'hC3, 4'd10},
        '{K_CMP, 8'h22, 8'h41, 4'd10},
        '{K_CMP, 8'h23, 8'h03, 4'd10},
        '{K_CMP, 8'h24, 8'hFE, 4'd10},
        '{K_WR,  8'h23, 8'h00, 4'd10},
        '{K_CMP, 8'h23, 8'h03, 4'd10},
        '{K_WR,  8'h50, 8'h12, 4'd11},  // R11 unimplemented index
        '{K_CMP, 8'h50, 8'h00, 4'd11},
        '{K_WR,  8'h07, 8'h05, 4'd9},   // R9 out-of-range device
        '{K_WR,  8'h30, 8'h01, 4'd9},
        '{K_CMP, 8'h30, 8'h00, 4'd9},
        '{K_WR,  8'h07, 8'h02, 4'd13},  // R13 device 2 kept its value
        '{K_CMP, 8'h34, 8'h78, 4'd13}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic reg_write(input logic [7:0] i, input logic [7:0] v);
        io_write(IDX_P, i);
        io_write(DAT_P, v);
    endtask

    task automatic reg_read(input logic [7:0] i, output logic [7:0] v);
        io_write(IDX_P, i);
        io_read(DAT_P, v);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cfg_mode", 64'(cfg_mode), 64'd0);
        chk("R1 io_rdata", 64'(io_rdata), 64'h00);
        chk("R1 dev_active", 64'(dev_active), 64'd0);
        chk("R1 dev_base", 64'(dev_base), 64'd0);
        chk("R1 dev_cfgsel", 64'(dev_cfgsel), 64'd0);

        // R2 closed port behaviour
        io_read(DAT_P, rb);
        chk("R2 closed data read", 64'(rb), 64'hFF);
        io_read(IDX_P, rb);
        chk("R2 closed index read", 64'(rb), 64'hFF);
        io_write(IDX_P, 8'h07);
        chk("R2 non-key stays closed", 64'(cfg_mode), 64'd0);
        io_write(DAT_P, 8'h11);
        chk("R2 closed write active", 64'(dev_active), 64'd0);
        chk("R2 closed write cfgsel", 64'(dev_cfgsel), 64'd0);

        // R3 open the port
        io_write(IDX_P, 8'h55);
        chk("R3 open key", 64'(cfg_mode), 64'd1);

        // R4 index unchanged by the closed write, then loaded
        io_read(IDX_P, rb);
        chk("R4 index after closed write", 64'(rb), 64'h00);
        io_write(IDX_P, 8'h3C);
        io_read(IDX_P, rb);
        chk("R4 index readback", 64'(rb), 64'h3C);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].kind == K_WR) begin
                reg_write(VEC[i].idx, VEC[i].val);
            end else begin
                reg_read(VEC[i].idx, rb);
                chk($sformatf("R%0d idx %0h", VEC[i].req, VEC[i].idx), 64'(rb), 64'(VEC[i].val));
            end
        end

        // R6 R7 R8 outputs at the ports
        chk("R6 dev_active", 64'(dev_active), 64'b0110);
        chk("R7 dev_base", 64'(dev_base), 64'h0000_5678_0000_0000);
        chk("R8 dev_cfgsel", 64'(dev_cfgsel), 64'h009C_0000);

        // R12 read data holds
        reg_read(8'h20, rb);
        repeat (5) @(negedge clk);
        chk("R12 hold", 64'(io_rdata), 64'hA5);

        // R3 close the port
        io_write(IDX_P, 8'hAA);
        chk("R3 close key", 64'(cfg_mode), 64'd0);
        io_read(DAT_P, rb);
        chk("R2 data read after close", 64'(rb), 64'hFF);
        io_write(DAT_P, 8'h00);
        chk("R2 write after close active", 64'(dev_active), 64'b0110);
        chk("R2 write after close base", 64'(dev_base), 64'h0000_5678_0000_0000);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule